// File: doc/BRIEF.md
# Core Idle Retention Entry Controller

This block sits beside one processor core and decides when that core may be offered a retention state by an external power controller. It holds a 32-bit control register with two 3-bit delay codes, one applied when the core idles waiting for an interrupt and one applied when it idles waiting for an event. It also holds a single power-down enable bit. The register is written through a simple write port that carries the privilege level of the writer. Writes from the middle privilege levels succeed only when a separate permission input allows them.

While the core is idle, the block counts pulses of a system-counter tick input, which is synchronous to the core clock. Once the coded minimum number of ticks has been seen since idle entry, it raises a registered retention-ready indication toward the power controller. It reports a registered power-down request whenever the core is in wait-for-interrupt idle with the enable bit set. Waking from idle clears the count, and the next idle period starts again from zero.

Top module: `ret_entry_ctrl`

## Requirements
- R1: While the reset is active and after it is released, the register holds all zeros. `ret_ready`, `pwrdn_req` and `cfg_rd_data` all read 0 until they are written or stimulated.
- R2: Register layout: bit 0 is the power-down enable, bits [6:4] are the interrupt-idle delay code, and bits [9:7] are the event-idle delay code. All other bits read as 0 and ignore writes. `cfg_rd_data` shows the register contents one clock after they change.
- R3: A write with `cfg_wr_priv` = 3 always succeeds. A write with priv 1 or 2 succeeds only when `lower_wr_allow` is 1. A write with priv 0 never succeeds. A blocked write leaves the register unchanged.
- R4: Delay code 0 disables retention for its idle type, so `ret_ready` stays 0 for the whole of such an idle period.
- R5: Delay codes 1 to 7 require 2, 8, 32, 64, 128, 256 and 512 ticks respectively.
- R6: A tick is counted only in a cycle where `tick` is 1 and the core is idle (`idle_wfi` or `idle_wfe` is 1), including the entry cycle. `ret_ready` becomes 1 at the clock edge that ends the cycle holding the required tick, and it stays 1 while the idle period lasts.
- R7: At the first clock edge in a cycle with neither idle input high, `ret_ready` drops to 0 and the count returns to zero. The next idle period counts from zero.
- R8: The delay is fixed at idle entry. A register write during an idle period affects only the next idle period.
- R9: `pwrdn_req` is set at each clock edge ending a cycle in which `idle_wfi` is 1 and the enable bit is 1. It is cleared otherwise.
- R10: In the entry cycle, if `idle_wfi` is 1 the interrupt-idle code is chosen; otherwise the event-idle code is chosen. This holds even when both idle inputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_data | input | 32 | Register write data |
| cfg_wr_priv | input | 2 | Privilege level of the writer, 0 lowest to 3 highest |
| lower_wr_allow | input | 1 | Permits writes at privilege 1 and 2 |
| idle_wfi | input | 1 | Core is idle waiting for an interrupt |
| idle_wfe | input | 1 | Core is idle waiting for an event |
| tick | input | 1 | Single-cycle system-counter tick pulse |
| cfg_rd_data | output | 32 | Registered register read value |
| ret_ready | output | 1 | Retention may be offered to the power controller |
| pwrdn_req | output | 1 | Core requests power down |

## Verification
The hardest condition to reach from the ports is the largest delay code. To get there, the core must stay idle across 512 tick pulses with no wake-up and no interfering register rewrite, and random idle toggling almost never produces that. Directed sequences therefore walk every code with a tick on every cycle and count the cycles until ready appears. A rewrite in the middle of an idle period shows that the latched delay is kept. Long random runs use rare idle changes and sparse ticks, and they mix in permitted, blocked and lowest-privilege writes. A cycle-level bench model predicts every output on every cycle.

// File: rtl/ret_entry_pkg.sv
package ret_entry_pkg;
  localparam int REG_W   = 32;
  localparam int CODE_W  = 3;
  localparam int CNT_W   = 10;
  localparam int PD_BIT  = 0;
  localparam int WFI_LSB = 4;
  localparam int WFE_LSB = 7;

  typedef struct packed {
    logic [CODE_W-1:0] wfe_code;
    logic [CODE_W-1:0] wfi_code;
    logic              pd_en;
  } ret_cfg_t;

  // Nonlinear code to tick count: 0 -> off, 1 -> 2, 2 -> 8, n>=3 -> 2^(n+2)
  function automatic logic [CNT_W-1:0] code_to_ticks(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] lim;
    case (code)
      3'd0:    lim = '0;
      3'd1:    lim = CNT_W'(2);
      3'd2:    lim = CNT_W'(8);
      default: lim = CNT_W'(1) << ({1'b0, code} + 4'd2);
    endcase
    return lim;
  endfunction
endpackage

// File: rtl/ret_cfg_reg.sv
module ret_cfg_reg
  import ret_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [1:0]       wr_priv,
  input  logic             lower_wr_allow,
  output ret_cfg_t         cfg_o,
  output logic [REG_W-1:0] rd_data_o
);
  ret_cfg_t         cfg_q, cfg_d;
  logic [REG_W-1:0] rd_q, rd_d;
  logic             wr_ok;

  always_comb begin
    wr_ok = wr_en && ((wr_priv == 2'd3) ||
                      ((wr_priv != 2'd0) && lower_wr_allow));
    cfg_d = cfg_q;
    if (wr_ok) begin
      cfg_d.pd_en    = wr_data[PD_BIT];
      cfg_d.wfi_code = wr_data[WFI_LSB +: CODE_W];
      cfg_d.wfe_code = wr_data[WFE_LSB +: CODE_W];
    end
    rd_d                      = '0;
    rd_d[PD_BIT]              = cfg_q.pd_en;
    rd_d[WFI_LSB +: CODE_W]   = cfg_q.wfi_code;
    rd_d[WFE_LSB +: CODE_W]   = cfg_q.wfe_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      rd_q  <= '0;
    end else begin
      cfg_q <= cfg_d;
      rd_q  <= rd_d;
    end
  end

  assign cfg_o     = cfg_q;
  assign rd_data_o = rd_q;

  // R3: the lowest privilege never changes the register
  p_low_priv_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_priv == 2'd0) |=> $stable(cfg_q));
  // R3: middle privilege without permission is blocked
  p_no_perm_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_priv != 2'd3 && !lower_wr_allow) |=> $stable(cfg_q));
endmodule

// File: rtl/ret_tick_timer.sv
module ret_tick_timer
  import ret_entry_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     idle_wfi,
  input  logic     idle_wfe,
  input  logic     tick,
  input  ret_cfg_t cfg,
  output logic     ready_o,
  output logic     pwrdn_o
);
  logic             idle_now, idle_q;
  logic [CNT_W-1:0] lim_q, lim_d, lim_eff;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ready_q, ready_d, pd_q, pd_d;

  always_comb begin
    idle_now = idle_wfi || idle_wfe;
    lim_eff  = idle_q ? lim_q
                      : code_to_ticks(idle_wfi ? cfg.wfi_code : cfg.wfe_code);
    lim_d    = lim_eff;
    cnt_d    = '0;
    if (idle_now) begin
      cnt_d = cnt_q;
      if (tick && (cnt_q < lim_eff)) cnt_d = cnt_q + CNT_W'(1);
    end
    ready_d = idle_now && (lim_eff != '0) && (cnt_d >= lim_eff);
    pd_d    = idle_wfi && cfg.pd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 1'b0;
      lim_q   <= '0;
      cnt_q   <= '0;
      ready_q <= 1'b0;
      pd_q    <= 1'b0;
    end else begin
      idle_q  <= idle_now;
      lim_q   <= lim_d;
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
      pd_q    <= pd_d;
    end
  end

  assign ready_o = ready_q;
  assign pwrdn_o = pd_q;

  // R7: outside idle the count is cleared and ready drops
  p_wake_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_now |=> (cnt_q == '0) && !ready_o);
  // R6: the count never passes the latched limit during idle
  p_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |-> cnt_q <= lim_q);
  // R8: the limit stays frozen while idle continues
  p_limit_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q && idle_now) |=> $stable(lim_q));
  // R4: a zero limit never yields readiness
  p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_now && lim_eff == '0) |=> !ready_o);
  // R9: a power-down request needs interrupt idle the cycle before
  p_pd_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwrdn_o) |-> $past(idle_wfi));
endmodule

// File: rtl/ret_entry_ctrl.sv
module ret_entry_ctrl
  import ret_entry_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [REG_W-1:0] cfg_wr_data,
  input  logic [1:0]       cfg_wr_priv,
  input  logic             lower_wr_allow,
  input  logic             idle_wfi,
  input  logic             idle_wfe,
  input  logic             tick,
  output logic [REG_W-1:0] cfg_rd_data,
  output logic             ret_ready,
  output logic             pwrdn_req
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  ret_cfg_t   cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ret_cfg_reg u_cfg (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .wr_en          (cfg_wr_en),
    .wr_data        (cfg_wr_data),
    .wr_priv        (cfg_wr_priv),
    .lower_wr_allow (lower_wr_allow),
    .cfg_o          (cfg),
    .rd_data_o      (cfg_rd_data)
  );

  ret_tick_timer u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .idle_wfi (idle_wfi),
    .idle_wfe (idle_wfe),
    .tick     (tick),
    .cfg      (cfg),
    .ready_o  (ret_ready),
    .pwrdn_o  (pwrdn_req)
  );

  // R2: reserved read positions stay zero
  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_rd_data[REG_W-1:WFE_LSB+CODE_W] == '0) && (cfg_rd_data[WFI_LSB-1:PD_BIT+1] == '0));
  // R6: readiness only rises out of an idle cycle
  p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(ret_ready) |-> $past(idle_wfi || idle_wfe));
endmodule

// File: tb/ret_entry_ctrl_tb_top.sv
module ret_entry_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [31:0] cfg_wr_data;
  logic [1:0]  cfg_wr_priv;
  logic        lower_wr_allow;
  logic        idle_wfi, idle_wfe, tick;
  logic [31:0] cfg_rd_data;
  logic        ret_ready, pwrdn_req;

  int n_chk = 0;
  int n_bad = 0;
  string tag = "R6";

  // model state
  logic [2:0] m_wfi, m_wfe;
  logic       m_pd, m_idle_q, m_ready, m_pdreq;
  int         m_lim, m_cnt;
  logic [31:0] m_rd;

  always #2.5 clk = ~clk;

  ret_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_wr_priv(cfg_wr_priv), .lower_wr_allow(lower_wr_allow),
    .idle_wfi(idle_wfi), .idle_wfe(idle_wfe), .tick(tick),
    .cfg_rd_data(cfg_rd_data), .ret_ready(ret_ready), .pwrdn_req(pwrdn_req)
  );

  function automatic int ticks_for(input logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 2;
      3'd2: return 8;
      3'd3: return 32;
      3'd4: return 64;
      3'd5: return 128;
      3'd6: return 256;
      default: return 512;
    endcase
  endfunction

  function automatic logic [31:0] pack(input logic [2:0] e, input logic [2:0] i, input logic p);
    return {22'd0, e, i, 3'd0, p};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_wfi = 0; m_wfe = 0; m_pd = 0; m_idle_q = 0; m_ready = 0; m_pdreq = 0;
    m_lim = 0; m_cnt = 0; m_rd = 0;
  endtask

  // one cycle: drive at negedge, model the edge, check at next negedge
  task automatic step(input logic wr, input logic [31:0] d, input logic [1:0] pr,
                      input logic al, input logic wi, input logic we, input logic tk);
    logic idle;
    int   eff, cnt_n;
    cfg_wr_en = wr; cfg_wr_data = d; cfg_wr_priv = pr; lower_wr_allow = al;
    idle_wfi = wi; idle_wfe = we; tick = tk;
    idle = wi | we;
    eff = m_idle_q ? m_lim : ticks_for(wi ? m_wfi : m_wfe);
    cnt_n = 0;
    if (idle) cnt_n = (tk && m_cnt < eff) ? m_cnt + 1 : m_cnt;
    m_ready = idle && eff != 0 && cnt_n >= eff;
    m_pdreq = wi && m_pd;
    m_rd = pack(m_wfe, m_wfi, m_pd);
    if (wr && (pr == 2'd3 || (pr != 2'd0 && al))) begin
      m_pd = d[0]; m_wfi = d[6:4]; m_wfe = d[9:7];
    end
    m_lim = eff; m_cnt = cnt_n; m_idle_q = idle;
    @(posedge clk);
    @(negedge clk);
    chk(tag, int'(ret_ready), int'(m_ready));
    chk("R9", int'(pwrdn_req), int'(m_pdreq));
    chk("R2", int'(cfg_rd_data), int'(m_rd));
  endtask

  task automatic wr_cfg(input logic [2:0] e, input logic [2:0] i, input logic p);
    step(1, pack(e, i, p) | 32'hFFFF_FC0E, 2'd3, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int cyc;
    logic iw, ie, lvl;
    void'($urandom(32'd1234));
    rst_n = 0; cfg_wr_en = 0; cfg_wr_data = 0; cfg_wr_priv = 0; lower_wr_allow = 0;
    idle_wfi = 0; idle_wfe = 0; tick = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", int'(ret_ready), 0);
    chk("R1", int'(pwrdn_req), 0);
    chk("R1", int'(cfg_rd_data), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    tag = "R1";
    step(0, 0, 0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0);

    // R2: reserved write bits ignored, layout
    tag = "R2";
    wr_cfg(3'd5, 3'd2, 1);
    chk("R2", int'(cfg_rd_data), int'(32'h0000_02A1));

    // R3: privilege gating
    tag = "R3";
    step(1, 32'h0, 2'd0, 1, 0, 0, 0); step(0, 0, 0, 0, 0, 0, 0);
    chk("R3", int'(cfg_rd_data), int'(32'h0000_02A1));
    step(1, 32'h0, 2'd1, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0, 0);
    chk("R3", int'(cfg_rd_data), int'(32'h0000_02A1));
    step(1, 32'h0, 2'd2, 1, 0, 0, 0); step(0, 0, 0, 0, 0, 0, 0);
    chk("R3", int'(cfg_rd_data), 0);

    // R5: every code with a tick each cycle
    tag = "R5";
    for (int c = 1; c < 8; c++) begin
      wr_cfg(3'd0, 3'(c), 0);
      cyc = 0;
      while (!ret_ready && cyc < 600) begin
        step(0, 0, 0, 0, 1, 0, 1);
        cyc++;
      end
      chk("R5", cyc, ticks_for(3'(c)));
      step(0, 0, 0, 0, 1, 0, 0);
      chk("R6", int'(ret_ready), 1);
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R7", int'(ret_ready), 0);
    end

    // R4: code zero for event idle
    tag = "R4";
    wr_cfg(3'd0, 3'd1, 0);
    repeat (20) step(0, 0, 0, 0, 0, 1, 1);
    chk("R4", int'(ret_ready), 0);
    step(0, 0, 0, 0, 0, 0, 0);

    // R7: restart from zero after wake
    tag = "R7";
    step(0, 0, 0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1, 0, 1);
    chk("R7", int'(ret_ready), 0);
    step(0, 0, 0, 0, 1, 0, 1);
    chk("R7", int'(ret_ready), 1);
    step(0, 0, 0, 0, 0, 0, 0);

    // R8: rewrite during idle keeps the latched delay
    tag = "R8";
    wr_cfg(3'd0, 3'd3, 0);
    repeat (5) step(0, 0, 0, 0, 1, 0, 1);
    step(1, pack(3'd0, 3'd1, 0), 2'd3, 0, 1, 0, 1);
    repeat (10) step(0, 0, 0, 0, 1, 0, 1);
    chk("R8", int'(ret_ready), 0);
    repeat (16) step(0, 0, 0, 0, 1, 0, 1);
    chk("R8", int'(ret_ready), 1);
    step(0, 0, 0, 0, 0, 0, 0);

    // R10: both idle inputs, interrupt code wins
    tag = "R10";
    wr_cfg(3'd7, 3'd2, 1);
    repeat (8) step(0, 0, 0, 0, 1, 1, 1);
    chk("R10", int'(ret_ready), 1);
    chk("R9", int'(pwrdn_req), 1);
    step(0, 0, 0, 0, 0, 1, 0);
    chk("R9", int'(pwrdn_req), 0);
    step(0, 0, 0, 0, 0, 0, 0);

    // random phase
    tag = "R6";
    iw = 0; ie = 0;
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] d;
      logic        w;
      if ($urandom_range(0, 40) == 0) begin
        lvl = $urandom_range(0, 1);
        iw = lvl & $urandom_range(0, 1);
        ie = lvl & ($urandom_range(0, 1) | ~iw);
      end
      w = ($urandom_range(0, 15) == 0);
      d = $urandom;
      if ($urandom_range(0, 1)) d[9:4] = {3'($urandom_range(0, 2)), 3'($urandom_range(0, 2))};
      step(w, d, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), iw, ie,
           ($urandom_range(0, 2) == 0));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule